// File: doc/BRIEF.md
# Trap Entry State Sequencer

This block carries out the state changes a windowed-register processor core makes when it takes a trap, and undoes them when the trap returns. When a trap request arrives, the block raises the trap level by one. It saves the running context (program counter, next program counter, condition codes, address space identifier, processor state word and current window pointer) together with the trap type into the frame for the new level. It then produces the redirected program counters that point into the trap table, a processor state word forced into its handler form, and a window pointer corrected according to the trap type.

A trap return pops the frame at the current level. The saved context goes back onto the outputs and the level drops by one. A trap requested while the level already sits at its ceiling is refused: the block reports it on an error pulse, and the stack is left as it was. Every output is registered, so results appear one clock after the request is sampled.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the trap level is 0, `tt_o` is 0, all result outputs are 0, and none of `redir_vld`, `ret_vld` or `tl_err` is high.
- R2: A trap request sampled while the level is below `MAX_TL` raises the level by one and pulses `redir_vld` for exactly one cycle on the next clock.
- R3: On trap entry `nxt_pstate` is the incoming state word with these bits set: bit 0 (alternate globals) = 1, bit 1 (interrupt enable) = 0, bit 2 (privileged) = 1, bit 3 (address mask) = 0, bit 4 (FPU enable) = `HAS_FPU`, bit 5 (error state) = 0. Bit 9 (current little-endian) takes the value of bit 8 (trap little-endian). Bits 8:6 are kept.
- R4: For trap type 0x024 the new window pointer is the current one plus 1, modulo `NWIN`.
- R5: For trap types 0x080 to 0x0BF the new window pointer is current + saved-window count + 2, modulo `NWIN`.
- R6: For trap types 0x0C0 to 0x0FF the new window pointer is current − 1, modulo `NWIN`. For every other type, including misaligned access 0x034, it is unchanged.
- R7: `nxt_pc` on entry is {`trap_base`[63:15], L, type[8:0], 5'b00000}, where L is 1 when the level was non-zero before entry. `nxt_npc` is the same address with the low five bits 5'b00100.
- R8: A trap request sampled at level `MAX_TL` pulses `tl_err`, leaves the level and every saved frame unchanged, and raises no redirect.
- R9: A return sampled at level L > 0 drives onto the outputs the PC, nPC, condition codes, ASI, state word and window pointer saved at level L, pulses `ret_vld`, and sets the level to L − 1. Frames come back in last-in first-out order.
- R10: A return at level 0 has no effect on any output. When a return and a trap request arrive in the same cycle, the trap is taken and the return is dropped.
- R11: `tt_o` shows the trap type saved at the current level, and 0 at level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_req | input | 1 | Request to take a trap this cycle |
| trap_tt | input | 9 | Trap type of the request |
| trap_ret | input | 1 | Request to return from the current level |
| cur_pc | input | 64 | Running program counter |
| cur_npc | input | 64 | Running next program counter |
| cur_ccr | input | 8 | Condition codes |
| cur_asi | input | 8 | Address space identifier |
| cur_pstate | input | 10 | Processor state word |
| cur_cwp | input | CWP_W (3) | Current window pointer |
| cur_cansave | input | CWP_W (3) | Count of windows that can still be saved |
| trap_base | input | 49 | Trap table base, address bits 63:15 |
| tl_o | output | TL_W (3) | Current trap level |
| tt_o | output | 9 | Trap type saved at the current level |
| redir_vld | output | 1 | One-cycle pulse: a trap was taken |
| ret_vld | output | 1 | One-cycle pulse: a return was performed |
| tl_err | output | 1 | One-cycle pulse: trap refused at maximum level |
| nxt_pc | output | 64 | Redirect or restored program counter |
| nxt_npc | output | 64 | Redirect or restored next program counter |
| nxt_pstate | output | 10 | Forced or restored state word |
| nxt_cwp | output | CWP_W (3) | Adjusted or restored window pointer |
| nxt_ccr | output | 8 | Condition codes (passed through on entry, restored on return) |
| nxt_asi | output | 8 | ASI (passed through on entry, restored on return) |

## Verification
The hardest state to reach is a completely full frame stack with a further trap pending. Only there can the refusal path be seen to leave all saved frames intact, and only a long chain of distinct frames shows that a return reads the right level. The stimulus nests traps one after another up to the ceiling, each with its own PC and type, and then fires one more. It then unwinds the whole chain and compares each restored frame with what was pushed at that depth. A sweep over all 512 trap types, each followed by a return, covers every window correction and every window/save-count pairing in the spill range.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    localparam int VA_W  = 64;
    localparam int TT_W  = 9;
    localparam int PS_W  = 10;
    localparam int TB_W  = 49;

    // state word bit positions
    localparam int PS_AG   = 0;
    localparam int PS_IE   = 1;
    localparam int PS_PRIV = 2;
    localparam int PS_AM   = 3;
    localparam int PS_PEF  = 4;
    localparam int PS_RED  = 5;
    localparam int PS_TLE  = 8;
    localparam int PS_CLE  = 9;

    localparam logic [TT_W-1:0] TT_CLEAN_WIN = 9'h024;
    localparam logic [TT_W-1:0] TT_MISALIGN  = 9'h034;

    typedef enum logic [1:0] {
        WADJ_NONE,
        WADJ_CLEAN,
        WADJ_SPILL,
        WADJ_FILL
    } wadj_e;

    typedef struct packed {
        logic [VA_W-1:0] pc;
        logic [VA_W-1:0] npc;
        logic [7:0]      ccr;
        logic [7:0]      asi;
        logic [PS_W-1:0] pstate;
        logic [TT_W-1:0] tt;
    } tframe_t;

    function automatic wadj_e classify_tt(input logic [TT_W-1:0] tt);
        wadj_e k;
        k = WADJ_NONE;
        if (tt == TT_CLEAN_WIN)
            k = WADJ_CLEAN;
        else if (!tt[8] && tt[7:6] == 2'b10)
            k = WADJ_SPILL;
        else if (!tt[8] && tt[7:6] == 2'b11)
            k = WADJ_FILL;
        return k;
    endfunction

endpackage

// File: rtl/trap_pstate_force.sv
module trap_pstate_force
    import trap_seq_pkg::*;
#(
    parameter bit HAS_FPU = 1'b1
) (
    input  logic [PS_W-1:0] ps_in,
    output logic [PS_W-1:0] ps_out
);

    always_comb begin
        ps_out          = ps_in;
        ps_out[PS_AG]   = 1'b1;
        ps_out[PS_IE]   = 1'b0;
        ps_out[PS_PRIV] = 1'b1;
        ps_out[PS_AM]   = 1'b0;
        ps_out[PS_PEF]  = HAS_FPU;
        ps_out[PS_RED]  = 1'b0;
        ps_out[PS_CLE]  = ps_in[PS_TLE];
    end

endmodule

// File: rtl/trap_cwp_adjust.sv
module trap_cwp_adjust
    import trap_seq_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int CWP_W = 3
) (
    input  logic [TT_W-1:0]  tt,
    input  logic [CWP_W-1:0] cwp_in,
    input  logic [CWP_W-1:0] cansave,
    output logic [CWP_W-1:0] cwp_out
);

    localparam int SUM_W = CWP_W + 2;

    wadj_e                kind;
    logic [SUM_W-1:0]     spill_sum;
    logic [CWP_W-1:0]     clean_w;
    logic [CWP_W-1:0]     spill_w;
    logic [CWP_W-1:0]     fill_w;

    always_comb begin
        kind      = classify_tt(tt);
        spill_sum = {2'b00, cwp_in} + {2'b00, cansave} + SUM_W'(2);
        clean_w   = CWP_W'((32'(cwp_in) + 32'd1) % NWIN);
        spill_w   = CWP_W'(32'(spill_sum) % NWIN);
        fill_w    = CWP_W'((32'(cwp_in) + NWIN - 1) % NWIN);
        unique case (kind)
            WADJ_CLEAN: cwp_out = clean_w;
            WADJ_SPILL: cwp_out = spill_w;
            WADJ_FILL:  cwp_out = fill_w;
            default:    cwp_out = cwp_in;
        endcase
    end

endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
    import trap_seq_pkg::*;
(
    input  logic [TB_W-1:0] base,
    input  logic            tl_nz,
    input  logic [TT_W-1:0] tt,
    output logic [VA_W-1:0] vec_pc,
    output logic [VA_W-1:0] vec_npc
);

    always_comb begin
        vec_pc  = {base, tl_nz, tt, 5'b00000};
        vec_npc = {base, tl_nz, tt, 5'b00100};
    end

endmodule

// File: rtl/trap_frame_stack.sv
module trap_frame_stack
    import trap_seq_pkg::*;
#(
    parameter int MAX_TL = 5,
    parameter int TL_W   = 3,
    parameter int CWP_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic [TL_W-1:0]  push_idx,
    input  tframe_t          push_frame,
    input  logic [CWP_W-1:0] push_cwp,
    input  logic [TL_W-1:0]  rd_idx,
    output tframe_t          rd_frame,
    output logic [CWP_W-1:0] rd_cwp
);

    tframe_t          frm_q [1:MAX_TL];
    logic [CWP_W-1:0] cwp_q [1:MAX_TL];

    for (genvar g = 1; g <= MAX_TL; g++) begin : g_lvl
        tframe_t          frm_d;
        logic [CWP_W-1:0] cwp_d;
        logic             hit;

        always_comb begin
            hit   = push_en && (push_idx == TL_W'(g));
            frm_d = hit ? push_frame : frm_q[g];
            cwp_d = hit ? push_cwp   : cwp_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                frm_q[g] <= '0;
                cwp_q[g] <= '0;
            end else begin
                frm_q[g] <= frm_d;
                cwp_q[g] <= cwp_d;
            end
        end
    end

    always_comb begin
        rd_frame = '0;
        rd_cwp   = '0;
        for (int i = 1; i <= MAX_TL; i++) begin
            if (rd_idx == TL_W'(i)) begin
                rd_frame = frm_q[i];
                rd_cwp   = cwp_q[i];
            end
        end
    end

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
    import trap_seq_pkg::*;
#(
    parameter int MAX_TL  = 5,
    parameter int NWIN    = 8,
    parameter bit HAS_FPU = 1'b1,
    localparam int TL_W   = $clog2(MAX_TL + 1),
    localparam int CWP_W  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req,
    input  logic [TT_W-1:0]  trap_tt,
    input  logic             trap_ret,
    input  logic [VA_W-1:0]  cur_pc,
    input  logic [VA_W-1:0]  cur_npc,
    input  logic [7:0]       cur_ccr,
    input  logic [7:0]       cur_asi,
    input  logic [PS_W-1:0]  cur_pstate,
    input  logic [CWP_W-1:0] cur_cwp,
    input  logic [CWP_W-1:0] cur_cansave,
    input  logic [TB_W-1:0]  trap_base,
    output logic [TL_W-1:0]  tl_o,
    output logic [TT_W-1:0]  tt_o,
    output logic             redir_vld,
    output logic             ret_vld,
    output logic             tl_err,
    output logic [VA_W-1:0]  nxt_pc,
    output logic [VA_W-1:0]  nxt_npc,
    output logic [PS_W-1:0]  nxt_pstate,
    output logic [CWP_W-1:0] nxt_cwp,
    output logic [7:0]       nxt_ccr,
    output logic [7:0]       nxt_asi
);

    localparam logic [TL_W-1:0] TL_TOP = TL_W'(MAX_TL);

    typedef struct packed {
        logic [TL_W-1:0]  tl;
        logic [VA_W-1:0]  pc;
        logic [VA_W-1:0]  npc;
        logic [PS_W-1:0]  pstate;
        logic [CWP_W-1:0] cwp;
        logic [7:0]       ccr;
        logic [7:0]       asi;
        logic             redir;
        logic             rtn;
        logic             err;
    } seq_st_t;

    seq_st_t s_d, s_q;

    logic             take_trap_d;
    logic             over_d;
    logic             take_ret_d;
    logic [TL_W-1:0]  push_idx_d;
    tframe_t          push_frame_d;
    tframe_t          rd_frame;
    logic [CWP_W-1:0] rd_cwp;
    logic [VA_W-1:0]  vec_pc;
    logic [VA_W-1:0]  vec_npc;
    logic [PS_W-1:0]  forced_ps;
    logic [CWP_W-1:0] adj_cwp;

    always_comb begin
        take_trap_d  = trap_req && (s_q.tl < TL_TOP);
        over_d       = trap_req && (s_q.tl == TL_TOP);
        take_ret_d   = trap_ret && !trap_req && (s_q.tl != '0);
        push_idx_d   = s_q.tl + TL_W'(1);
        push_frame_d = '{pc: cur_pc, npc: cur_npc, ccr: cur_ccr,
                         asi: cur_asi, pstate: cur_pstate, tt: trap_tt};
    end

    trap_pstate_force #(.HAS_FPU(HAS_FPU)) u_ps (
        .ps_in  (cur_pstate),
        .ps_out (forced_ps)
    );

    trap_cwp_adjust #(.NWIN(NWIN), .CWP_W(CWP_W)) u_cwp (
        .tt      (trap_tt),
        .cwp_in  (cur_cwp),
        .cansave (cur_cansave),
        .cwp_out (adj_cwp)
    );

    trap_vector_gen u_vec (
        .base    (trap_base),
        .tl_nz   (s_q.tl != '0),
        .tt      (trap_tt),
        .vec_pc  (vec_pc),
        .vec_npc (vec_npc)
    );

    trap_frame_stack #(.MAX_TL(MAX_TL), .TL_W(TL_W), .CWP_W(CWP_W)) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_en    (take_trap_d),
        .push_idx   (push_idx_d),
        .push_frame (push_frame_d),
        .push_cwp   (cur_cwp),
        .rd_idx     (s_q.tl),
        .rd_frame   (rd_frame),
        .rd_cwp     (rd_cwp)
    );

    always_comb begin
        s_d       = s_q;
        s_d.redir = 1'b0;
        s_d.rtn   = 1'b0;
        s_d.err   = 1'b0;
        if (take_trap_d) begin
            s_d.tl     = push_idx_d;
            s_d.pc     = vec_pc;
            s_d.npc    = vec_npc;
            s_d.pstate = forced_ps;
            s_d.cwp    = adj_cwp;
            s_d.ccr    = cur_ccr;
            s_d.asi    = cur_asi;
            s_d.redir  = 1'b1;
        end else if (over_d) begin
            s_d.err = 1'b1;
        end else if (take_ret_d) begin
            s_d.tl     = s_q.tl - TL_W'(1);
            s_d.pc     = rd_frame.pc;
            s_d.npc    = rd_frame.npc;
            s_d.pstate = rd_frame.pstate;
            s_d.cwp    = rd_cwp;
            s_d.ccr    = rd_frame.ccr;
            s_d.asi    = rd_frame.asi;
            s_d.rtn    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        tl_o       = s_q.tl;
        tt_o       = rd_frame.tt;
        redir_vld  = s_q.redir;
        ret_vld    = s_q.rtn;
        tl_err     = s_q.err;
        nxt_pc     = s_q.pc;
        nxt_npc    = s_q.npc;
        nxt_pstate = s_q.pstate;
        nxt_cwp    = s_q.cwp;
        nxt_ccr    = s_q.ccr;
        nxt_asi    = s_q.asi;
    end

endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk
    import trap_seq_pkg::*;
#(
    parameter int MAX_TL = 5,
    parameter int TL_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trap_req,
    input logic             trap_ret,
    input logic [TL_W-1:0]  tl_o,
    input logic             redir_vld,
    input logic             ret_vld,
    input logic             tl_err,
    input logic [VA_W-1:0]  nxt_pc,
    input logic [VA_W-1:0]  nxt_npc,
    input logic [PS_W-1:0]  nxt_pstate
);

    localparam logic [TL_W-1:0] TOP = TL_W'(MAX_TL);

    // R2
    entry_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && tl_o < TOP) |=> (redir_vld && tl_o == TL_W'($past(tl_o) + 1'b1)));

    // R8
    max_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && tl_o == TOP) |=> (tl_err && !redir_vld && tl_o == $past(tl_o)));

    // R8
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tl_o <= TOP);

    // R9
    return_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ret && !trap_req && tl_o != '0) |=> (ret_vld && tl_o == TL_W'($past(tl_o) - 1'b1)));

    // R10
    idle_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ret && !trap_req && tl_o == '0) |=> (!ret_vld && tl_o == '0));

    // R3
    entry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld |-> (nxt_pstate[PS_PRIV] && !nxt_pstate[PS_IE] && nxt_pstate[PS_AG]
                       && !nxt_pstate[PS_AM] && !nxt_pstate[PS_RED]));

    // R7
    vector_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld |-> (nxt_pc[4:0] == 5'b00000 && nxt_npc == (nxt_pc | 64'd4)));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({redir_vld, ret_vld, tl_err}));

endmodule

bind trap_entry_seq trap_entry_seq_chk #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_req   (trap_req),
    .trap_ret   (trap_ret),
    .tl_o       (tl_o),
    .redir_vld  (redir_vld),
    .ret_vld    (ret_vld),
    .tl_err     (tl_err),
    .nxt_pc     (nxt_pc),
    .nxt_npc    (nxt_npc),
    .nxt_pstate (nxt_pstate)
);

// File: tb/tb_trap_entry_seq.sv
module tb_trap_entry_seq;

    localparam int NW  = 8;
    localparam int MTL = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic [8:0]  trap_tt = '0;
    logic        trap_ret = 1'b0;
    logic [63:0] cur_pc = '0, cur_npc = '0;
    logic [7:0]  cur_ccr = '0, cur_asi = '0;
    logic [9:0]  cur_pstate = '0;
    logic [2:0]  cur_cwp = '0, cur_cansave = '0;
    logic [48:0] trap_base = '0;
    logic [2:0]  tl_o;
    logic [8:0]  tt_o;
    logic        redir_vld, ret_vld, tl_err;
    logic [63:0] nxt_pc, nxt_npc;
    logic [9:0]  nxt_pstate;
    logic [2:0]  nxt_cwp;
    logic [7:0]  nxt_ccr, nxt_asi;

    int errors = 0;
    int checks = 0;

    trap_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_tt(trap_tt),
        .trap_ret(trap_ret), .cur_pc(cur_pc), .cur_npc(cur_npc),
        .cur_ccr(cur_ccr), .cur_asi(cur_asi), .cur_pstate(cur_pstate),
        .cur_cwp(cur_cwp), .cur_cansave(cur_cansave), .trap_base(trap_base),
        .tl_o(tl_o), .tt_o(tt_o), .redir_vld(redir_vld), .ret_vld(ret_vld),
        .tl_err(tl_err), .nxt_pc(nxt_pc), .nxt_npc(nxt_npc),
        .nxt_pstate(nxt_pstate), .nxt_cwp(nxt_cwp), .nxt_ccr(nxt_ccr),
        .nxt_asi(nxt_asi)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [9:0] exp_ps(input logic [9:0] p);
        logic [9:0] r;
        r = (p & 10'b01_1100_0000) | 10'b00_0001_0101;
        if (p[8]) r = r | 10'b10_0000_0000;
        return r;
    endfunction

    function automatic logic [2:0] exp_cwp(input int t, input int c, input int s);
        if (t == 'h24) return 3'((c + 1) % NW);
        if (t >= 'h80 && t <= 'hBF) return 3'((c + s + 2) % NW);
        if (t >= 'hC0 && t <= 'hFF) return 3'((c + NW - 1) % NW);
        return 3'(c);
    endfunction

    function automatic logic [63:0] exp_vec(input logic [48:0] b, input int lnz, input int t);
        return (64'(b) * 64'd32768) + 64'(lnz) * 64'd16384 + 64'(t) * 64'd32;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [63:0] sv_pc [MTL];
        logic [63:0] hold;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "tl", 64'(tl_o), 0);
        chk("R1", "tt", 64'(tt_o), 0);
        chk("R1", "pulses", 64'({redir_vld, ret_vld, tl_err}), 0);
        chk("R1", "pc", nxt_pc, 0);
        chk("R1", "pstate", 64'(nxt_pstate), 0);

        // sweep every trap type: entry at level 0 then return
        for (int t = 0; t < 512; t++) begin
            logic [63:0] pc0, npc0;
            logic [7:0]  ccr0, asi0;
            logic [9:0]  ps0;
            logic [2:0]  cw0;
            int          cs0;
            pc0  = 64'h0000_4000_0000_0000 + 64'(t) * 64'd16;
            npc0 = pc0 + 64'd4;
            ccr0 = 8'(t) ^ 8'h5A;
            asi0 = 8'(t * 3);
            ps0  = 10'((t * 37) % 1024);
            cw0  = 3'(t % NW);
            cs0  = (t / 8) % NW;
            cur_pc = pc0; cur_npc = npc0; cur_ccr = ccr0; cur_asi = asi0;
            cur_pstate = ps0; cur_cwp = cw0; cur_cansave = 3'(cs0);
            trap_base = 49'h1_2345_6789_ABCD ^ 49'(t * 977);
            trap_tt = 9'(t); trap_req = 1'b1;
            tick();
            trap_req = 1'b0;
            chk("R2", "redir", 64'(redir_vld), 1);
            chk("R2", "tl", 64'(tl_o), 1);
            chk("R11", "tt", 64'(tt_o), 64'(t));
            chk("R3", "pstate", 64'(nxt_pstate), 64'(exp_ps(ps0)));
            if (t == 'h24) chk("R4", "cwp clean", 64'(nxt_cwp), 64'(exp_cwp(t, cw0, cs0)));
            else if (t >= 'h80 && t <= 'hBF) chk("R5", "cwp spill", 64'(nxt_cwp), 64'(exp_cwp(t, cw0, cs0)));
            else chk("R6", "cwp", 64'(nxt_cwp), 64'(exp_cwp(t, cw0, cs0)));
            chk("R7", "pc", nxt_pc, exp_vec(trap_base, 0, t));
            chk("R7", "npc", nxt_npc, exp_vec(trap_base, 0, t) + 64'd4);
            // scramble live inputs, then return
            cur_pc = ~pc0; cur_npc = ~npc0; cur_ccr = ~ccr0; cur_asi = ~asi0;
            cur_pstate = ~ps0; cur_cwp = ~cw0;
            trap_ret = 1'b1;
            tick();
            trap_ret = 1'b0;
            chk("R9", "ret", 64'(ret_vld), 1);
            chk("R9", "tl", 64'(tl_o), 0);
            chk("R9", "pc", nxt_pc, pc0);
            chk("R9", "npc", nxt_npc, npc0);
            chk("R9", "ccr/asi", 64'({nxt_ccr, nxt_asi}), 64'({ccr0, asi0}));
            chk("R9", "pstate", 64'(nxt_pstate), 64'(ps0));
            chk("R9", "cwp", 64'(nxt_cwp), 64'(cw0));
            chk("R11", "tt at 0", 64'(tt_o), 0);
        end

        // nest to the ceiling
        trap_base = 49'h0_0F0F_0F0F_0F0F;
        for (int lv = 0; lv < MTL; lv++) begin
            sv_pc[lv] = 64'h0000_0000_8000_0000 + 64'(lv) * 64'h100;
            cur_pc = sv_pc[lv]; cur_npc = sv_pc[lv] + 64'd4;
            trap_tt = 9'(9'h100 + lv); trap_req = 1'b1;
            tick();
            trap_req = 1'b0;
            chk("R2", "nest tl", 64'(tl_o), 64'(lv + 1));
            chk("R7", "nest pc", nxt_pc, exp_vec(trap_base, (lv > 0) ? 1 : 0, 'h100 + lv));
            chk("R11", "nest tt", 64'(tt_o), 64'('h100 + lv));
        end
        // R8 refused trap at maximum level
        hold = nxt_pc;
        cur_pc = 64'hDEAD_BEEF_0000_0000; trap_tt = 9'h1FF; trap_req = 1'b1;
        tick();
        trap_req = 1'b0;
        chk("R8", "err", 64'(tl_err), 1);
        chk("R8", "redir", 64'(redir_vld), 0);
        chk("R8", "tl", 64'(tl_o), MTL);
        chk("R8", "tt kept", 64'(tt_o), 64'('h100 + MTL - 1));
        chk("R8", "pc kept", nxt_pc, hold);
        // unwind in LIFO order
        for (int lv = MTL - 1; lv >= 0; lv--) begin
            trap_ret = 1'b1;
            tick();
            trap_ret = 1'b0;
            chk("R9", "unwind tl", 64'(tl_o), 64'(lv));
            chk("R9", "unwind pc", nxt_pc, sv_pc[lv]);
        end

        // R10 return at level 0 ignored
        hold = nxt_pc;
        trap_ret = 1'b1;
        tick();
        trap_ret = 1'b0;
        chk("R10", "idle ret_vld", 64'(ret_vld), 0);
        chk("R10", "idle tl", 64'(tl_o), 0);
        chk("R10", "idle pc", nxt_pc, hold);

        // R10 simultaneous request and return: trap wins
        trap_tt = 9'h010; trap_req = 1'b1;
        tick();
        cur_cwp = 3'd5; trap_tt = 9'h034; trap_ret = 1'b1;
        tick();
        trap_req = 1'b0; trap_ret = 1'b0;
        chk("R10", "both redir", 64'({redir_vld, ret_vld}), 64'(2'b10));
        chk("R10", "both tl", 64'(tl_o), 2);
        chk("R6", "misalign cwp", 64'(nxt_cwp), 5);
        chk("R11", "misalign tt", 64'(tt_o), 64'h34);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule